// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of a small cache-coherent shared-memory machine built from `NODES` processing nodes. For each memory line it owns, it records one of three directory states (no cached copies, read-only copies, one modified copy). It also records a presence vector that holds one bit per node. Nodes send read and write requests to it. The block answers only with point-to-point messages: line data, invalidations, and write-back requests to a modifying owner. Nothing is broadcast or snooped.

The controller serves one transaction at a time. A request that needs remote action marks its line busy until the last invalidation acknowledgement or the owner's write-back has arrived. While a line is busy, no new request is accepted. A small line array inside the block keeps the current value of each line. Each word resets to its own line index.

Top module: `coh_dir_home`

## Requirements
- R1: After reset, every line has no cached copies and an empty presence vector, line i holds the value i, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read of a line with no copies or with read-only copies returns a DATA message (`msg_type` 0) to the requester carrying the line. The requester is added as a sharer and the line becomes read-only shared.
- R3: A write to a shared line with other sharers sends one INV message (`msg_type` 1) to each sharer other than the writer, in ascending node order. No INV is ever sent to the requester.
- R4: Such a write is granted with an ACK message (`msg_type` 3) carrying the line, and only after one ACK response (`rsp_type` 0) per invalidation has come back. The writer then becomes the sole modifying holder.
- R5: A write to a line with no copies, a write by the only sharer and a write by the current modifying owner are granted at once with ACK, with no INV or WBREQ. The writer becomes the sole modifying holder.
- R6: A read of a modified line by a non-owner sends WBREQ (`msg_type` 2) with `msg_data` 0 (keep a read-only copy) to the owner. The block waits for a WB response (`rsp_type` 1) from that owner and stores its data. It then sends DATA with that data to the requester, and owner and requester are both recorded as sharers.
- R7: A write of a modified line by a non-owner sends WBREQ with `msg_data` 1 (drop the copy) to the owner. The stored value is the written-back data, and the grant is ACK carrying that data. The requester becomes sole modifying holder.
- R8: A read of a modified line by its own owner returns DATA at once, with no WBREQ, and leaves the line modified.
- R9: While invalidation acknowledgements or a write-back are outstanding, `req_ready` is 0.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the outgoing message stays valid and unchanged.
- R11: Message type codes are DATA=0, INV=1, WBREQ=2, ACK=3 on `msg_type`, and ACK=0, WB=1 on `rsp_type`.
- R12: A modified line has exactly one presence bit set, a line with no copies has none, and a shared line has at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_node | input | clog2(NODES) | Requesting node |
| req_line | input | clog2(LINES) | Line index |
| req_write | input | 1 | 1 = write (exclusive) request, 0 = read |
| rsp_valid | input | 1 | Node response offered |
| rsp_ready | output | 1 | Response taken (always 1) |
| rsp_node | input | clog2(NODES) | Responding node |
| rsp_type | input | 1 | 0 = invalidation ACK, 1 = write-back |
| rsp_data | input | DATA_W | Written-back line value |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Outgoing message taken |
| msg_type | output | 2 | DATA, INV, WBREQ or ACK |
| msg_node | output | clog2(NODES) | Destination node |
| msg_line | output | clog2(LINES) | Line index of the message |
| msg_data | output | DATA_W | Line value, or the drop flag for WBREQ |

## Verification
The checker assumes well-behaved nodes. Every ACK response answers an invalidation already sent, and WB responses come only from the owner after its WBREQ has been taken. Without this, its outstanding-acknowledgement count would be meaningless. The bench models each node this way. It acknowledges an invalidation in the cycle it takes it, or holds acknowledgements back on purpose. It returns a write-back one cycle after taking WBREQ, and it never sends a response nobody asked for.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_DRT = 2'd2
    } dir_st_e;

    typedef enum logic [1:0] {
        MSG_DATA  = 2'd0,
        MSG_INV   = 2'd1,
        MSG_WBREQ = 2'd2,
        MSG_ACK   = 2'd3
    } msg_e;

    localparam logic RSP_ACK = 1'b0;
    localparam logic RSP_WB  = 1'b1;

    typedef enum logic [2:0] {
        FS_IDLE   = 3'd0,
        FS_INV    = 3'd1,
        FS_ACKW   = 3'd2,
        FS_WBSEND = 3'd3,
        FS_WBWAIT = 3'd4,
        FS_REPLY  = 3'd5
    } fsm_e;

    typedef struct packed {
        dir_st_e st;
        logic    busy;
    } dir_ctl_t;

    function automatic int unsigned pop32(input logic [31:0] v);
        int unsigned c;
        c = 0;
        for (int i = 0; i < 32; i++) c = c + {31'b0, v[i]};
        return c;
    endfunction

    function automatic int unsigned low32(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 8,
    localparam int LIX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LIX_W-1:0]  rd_idx,
    output dir_ctl_t          rd_ctl,
    output logic [NODES-1:0]  rd_pres,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LIX_W-1:0]  wr_idx,
    input  dir_ctl_t          wr_ctl,
    input  logic [NODES-1:0]  wr_pres,
    input  logic              dwr_en,
    input  logic [DATA_W-1:0] dwr_data
);
    dir_ctl_t          ctl_q  [LINES];
    logic [NODES-1:0]  pres_q [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign rd_ctl  = ctl_q[rd_idx];
    assign rd_pres = pres_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                ctl_q[i]  <= '{st: DIR_UNC, busy: 1'b0};
                pres_q[i] <= '0;
                data_q[i] <= DATA_W'(i);
            end
        end else begin
            if (wr_en) begin
                ctl_q[wr_idx]  <= wr_ctl;
                pres_q[wr_idx] <= wr_pres;
            end
            if (dwr_en) data_q[wr_idx] <= dwr_data;
        end
    end
endmodule

// File: rtl/coh_dir_engine.sv
module coh_dir_engine
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 8,
    localparam int NID_W = $clog2(NODES),
    localparam int LIX_W = $clog2(LINES),
    localparam int CNT_W = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NID_W-1:0]  req_node,
    input  logic [LIX_W-1:0]  req_line,
    input  logic              req_write,
    input  logic              rsp_valid,
    input  logic [NID_W-1:0]  rsp_node,
    input  logic              rsp_type,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output msg_e              msg_type,
    output logic [NID_W-1:0]  msg_node,
    output logic [LIX_W-1:0]  msg_line,
    output logic [DATA_W-1:0] msg_data,
    output logic [LIX_W-1:0]  rd_idx,
    input  dir_ctl_t          rd_ctl,
    input  logic [NODES-1:0]  rd_pres,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output dir_ctl_t          wr_ctl,
    output logic [NODES-1:0]  wr_pres,
    output logic              dwr_en,
    output logic [DATA_W-1:0] dwr_data,
    output logic [NID_W-1:0]  cur_node_o
);
    fsm_e              fsm_q;
    logic [NID_W-1:0]  cur_node_q, owner_q;
    logic [LIX_W-1:0]  cur_line_q;
    logic              cur_wr_q;
    logic [NODES-1:0]  inv_mask_q;
    logic [CNT_W-1:0]  ack_cnt_q;
    msg_e              rep_type_q;
    logic [DATA_W-1:0] rep_data_q;

    logic              acc, wb_in, ack_dec, own_hit, quick_wr;
    logic [NODES-1:0]  req_bit, cur_bit, others, inv_low;
    logic [NID_W-1:0]  inv_node;

    assign rd_idx     = (fsm_q == FS_IDLE) ? req_line : cur_line_q;
    assign req_ready  = (fsm_q == FS_IDLE) && !rd_ctl.busy;
    assign acc        = req_valid && req_ready;
    assign req_bit    = NODES'(1) << req_node;
    assign cur_bit    = NODES'(1) << cur_node_q;
    assign others     = rd_pres & ~req_bit;
    assign own_hit    = rd_pres[req_node];
    assign quick_wr   = (rd_ctl.st == DIR_UNC) ||
                        (rd_ctl.st == DIR_SHR && others == '0) ||
                        (rd_ctl.st == DIR_DRT && own_hit);
    assign inv_node   = NID_W'(low32(32'(inv_mask_q)));
    assign inv_low    = NODES'(1) << inv_node;
    assign wb_in      = (fsm_q == FS_WBWAIT) && rsp_valid &&
                        (rsp_type == RSP_WB) && (rsp_node == owner_q);
    assign ack_dec    = (fsm_q == FS_INV || fsm_q == FS_ACKW) && rsp_valid &&
                        (rsp_type == RSP_ACK) && (ack_cnt_q != '0);
    assign cur_node_o = cur_node_q;
    assign msg_line   = cur_line_q;
    assign dwr_data   = rsp_data;
    assign dwr_en     = wb_in;

    // outgoing message view
    always_comb begin
        msg_valid = 1'b0;
        msg_type  = MSG_DATA;
        msg_node  = cur_node_q;
        msg_data  = '0;
        unique case (fsm_q)
            FS_INV: begin
                msg_valid = 1'b1;
                msg_type  = MSG_INV;
                msg_node  = inv_node;
            end
            FS_WBSEND: begin
                msg_valid = 1'b1;
                msg_type  = MSG_WBREQ;
                msg_node  = owner_q;
                msg_data  = DATA_W'(cur_wr_q);
            end
            FS_REPLY: begin
                msg_valid = 1'b1;
                msg_type  = rep_type_q;
                msg_data  = rep_data_q;
            end
            default: ;
        endcase
    end

    // directory entry updates
    always_comb begin
        wr_en   = 1'b0;
        wr_ctl  = rd_ctl;
        wr_pres = rd_pres;
        unique case (fsm_q)
            FS_IDLE: if (acc) begin
                wr_en = 1'b1;
                if (!req_write) begin
                    if (rd_ctl.st == DIR_DRT && !own_hit) wr_ctl.busy = 1'b1;
                    else if (rd_ctl.st != DIR_DRT) begin
                        wr_ctl.st = DIR_SHR;
                        wr_pres   = rd_pres | req_bit;
                    end
                end else if (quick_wr) begin
                    wr_ctl.st = DIR_DRT;
                    wr_pres   = req_bit;
                end else begin
                    wr_ctl.busy = 1'b1;
                end
            end
            FS_ACKW: if (ack_cnt_q == '0) begin
                wr_en   = 1'b1;
                wr_ctl  = '{st: DIR_DRT, busy: 1'b0};
                wr_pres = cur_bit;
            end
            FS_WBWAIT: if (wb_in) begin
                wr_en       = 1'b1;
                wr_ctl.busy = 1'b0;
                if (cur_wr_q) begin
                    wr_ctl.st = DIR_DRT;
                    wr_pres   = cur_bit;
                end else begin
                    wr_ctl.st = DIR_SHR;
                    wr_pres   = rd_pres | cur_bit;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q      <= FS_IDLE;
            cur_node_q <= '0;
            owner_q    <= '0;
            cur_line_q <= '0;
            cur_wr_q   <= 1'b0;
            inv_mask_q <= '0;
            ack_cnt_q  <= '0;
            rep_type_q <= MSG_DATA;
            rep_data_q <= '0;
        end else begin
            if (ack_dec) ack_cnt_q <= ack_cnt_q - CNT_W'(1);
            unique case (fsm_q)
                FS_IDLE: if (acc) begin
                    cur_node_q <= req_node;
                    cur_line_q <= req_line;
                    cur_wr_q   <= req_write;
                    rep_data_q <= rd_data;
                    owner_q    <= NID_W'(low32(32'(rd_pres)));
                    if (rd_ctl.st == DIR_DRT && !own_hit) begin
                        fsm_q <= FS_WBSEND;
                    end else if (!req_write) begin
                        rep_type_q <= MSG_DATA;
                        fsm_q      <= FS_REPLY;
                    end else if (quick_wr) begin
                        rep_type_q <= MSG_ACK;
                        fsm_q      <= FS_REPLY;
                    end else begin
                        inv_mask_q <= others;
                        ack_cnt_q  <= CNT_W'(pop32(32'(others)));
                        fsm_q      <= FS_INV;
                    end
                end
                FS_INV: if (msg_ready) begin
                    inv_mask_q <= inv_mask_q & ~inv_low;
                    if ((inv_mask_q & ~inv_low) == '0) fsm_q <= FS_ACKW;
                end
                FS_ACKW: if (ack_cnt_q == '0) begin
                    rep_type_q <= MSG_ACK;
                    fsm_q      <= FS_REPLY;
                end
                FS_WBSEND: if (msg_ready) fsm_q <= FS_WBWAIT;
                FS_WBWAIT: if (wb_in) begin
                    rep_data_q <= rsp_data;
                    rep_type_q <= cur_wr_q ? MSG_ACK : MSG_DATA;
                    fsm_q      <= FS_REPLY;
                end
                FS_REPLY: if (msg_ready) fsm_q <= FS_IDLE;
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 8,
    localparam int NID_W = $clog2(NODES),
    localparam int LIX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NID_W-1:0]  req_node,
    input  logic [LIX_W-1:0]  req_line,
    input  logic              req_write,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [NID_W-1:0]  rsp_node,
    input  logic              rsp_type,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_type,
    output logic [NID_W-1:0]  msg_node,
    output logic [LIX_W-1:0]  msg_line,
    output logic [DATA_W-1:0] msg_data
);
    logic [LIX_W-1:0]  rd_idx;
    dir_ctl_t          rd_ctl, wr_ctl;
    logic [NODES-1:0]  rd_pres, wr_pres;
    logic [DATA_W-1:0] rd_data, dwr_data;
    logic              wr_en, dwr_en;
    logic [NID_W-1:0]  cur_node_w;
    msg_e              msg_type_e;
    logic [1:0]        rd_st_w;

    assign rsp_ready = 1'b1;
    assign msg_type  = msg_type_e;
    assign rd_st_w   = rd_ctl.st;

    coh_dir_store #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_ctl(rd_ctl), .rd_pres(rd_pres),
        .rd_data(rd_data), .wr_en(wr_en), .wr_idx(rd_idx), .wr_ctl(wr_ctl),
        .wr_pres(wr_pres), .dwr_en(dwr_en), .dwr_data(dwr_data)
    );

    coh_dir_engine #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_node(req_node), .req_line(req_line), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_type(rsp_type),
        .rsp_data(rsp_data), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_type(msg_type_e), .msg_node(msg_node), .msg_line(msg_line),
        .msg_data(msg_data), .rd_idx(rd_idx), .rd_ctl(rd_ctl), .rd_pres(rd_pres),
        .rd_data(rd_data), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_pres(wr_pres),
        .dwr_en(dwr_en), .dwr_data(dwr_data), .cur_node_o(cur_node_w)
    );
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 8,
    localparam int NID_W = $clog2(NODES),
    localparam int LIX_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_type,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [1:0]        msg_type,
    input logic [NID_W-1:0]  msg_node,
    input logic [LIX_W-1:0]  msg_line,
    input logic [DATA_W-1:0] msg_data,
    input logic [NID_W-1:0]  cur_node,
    input logic [1:0]        rd_st,
    input logic [NODES-1:0]  rd_pres
);
    int   outst;
    logic wb_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst   <= 0;
            wb_pend <= 1'b0;
        end else begin
            outst <= outst
                     + ((msg_valid && msg_ready && msg_type == 2'd1) ? 1 : 0)
                     - ((rsp_valid && rsp_type == 1'b0) ? 1 : 0);
            if (msg_valid && msg_ready && msg_type == 2'd2) wb_pend <= 1'b1;
            else if (rsp_valid && rsp_type == 1'b1)         wb_pend <= 1'b0;
        end
    end

    a_r3_inv_not_requester: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_type == 2'd1 |-> msg_node != cur_node);

    a_r4_grant_after_acks: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_type == 2'd3 |-> outst == 0);

    a_r9_stall_on_acks: assert property (@(posedge clk) disable iff (rst)
        outst != 0 |-> !req_ready);

    a_r9_stall_on_wb: assert property (@(posedge clk) disable iff (rst)
        wb_pend |-> !req_ready);

    a_r10_msg_hold: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) &&
        $stable(msg_node) && $stable(msg_line) && $stable(msg_data));

    a_r12_dirty_single: assert property (@(posedge clk) disable iff (rst)
        rd_st == 2'd2 |-> $countones(rd_pres) == 1);

    a_r12_uncached_empty: assert property (@(posedge clk) disable iff (rst)
        rd_st == 2'd0 |-> rd_pres == '0);

    a_r12_shared_nonempty: assert property (@(posedge clk) disable iff (rst)
        rd_st == 2'd1 |-> rd_pres != '0);
endmodule

bind coh_dir_home coh_dir_chk #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_type(rsp_type), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_type(msg_type), .msg_node(msg_node), .msg_line(msg_line),
    .msg_data(msg_data), .cur_node(cur_node_w), .rd_st(rd_st_w), .rd_pres(rd_pres)
);

// File: tb/coh_dir_home_tb_top.sv
module coh_dir_home_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [1:0] req_node = '0;
    logic [2:0] req_line = '0;
    logic       rsp_valid = 1'b0, rsp_ready, rsp_type = 1'b0;
    logic [1:0] rsp_node = '0;
    logic [7:0] rsp_data = '0;
    logic       msg_valid, msg_ready = 1'b0;
    logic [1:0] msg_type, msg_node;
    logic [2:0] msg_line;
    logic [7:0] msg_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coh_dir_home dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_node(req_node), .req_line(req_line), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
        .rsp_type(rsp_type), .rsp_data(rsp_data), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_type(msg_type), .msg_node(msg_node),
        .msg_line(msg_line), .msg_data(msg_data)
    );

    // wr, node, line, final type, final data, expected INV mask,
    // WBREQ kind (0 none, 1 keep copy, 2 drop copy), owner, write-back data, requirement tag
    typedef struct packed {
        logic       wr;
        logic [1:0] node;
        logic [2:0] line;
        logic [1:0] fin;
        logic [7:0] fdata;
        logic [3:0] invm;
        logic [1:0] wbk;
        logic [1:0] own;
        logic [7:0] wbd;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'd3, 3'd1, 2'd0, 8'h01, 4'h0, 2'd0, 2'd0, 8'h00, 8'd2},  // R2, R1 data = index
        '{1'b0, 2'd1, 3'd1, 2'd0, 8'h01, 4'h0, 2'd0, 2'd0, 8'h00, 8'd2},  // R2 read of shared
        '{1'b1, 2'd3, 3'd1, 2'd3, 8'h01, 4'h2, 2'd0, 2'd0, 8'h00, 8'd3},  // R3 R4 inv node 1
        '{1'b0, 2'd2, 3'd1, 2'd0, 8'h5A, 4'h0, 2'd1, 2'd3, 8'h5A, 8'd6},  // R6
        '{1'b1, 2'd2, 3'd1, 2'd3, 8'h5A, 4'h8, 2'd0, 2'd0, 8'h00, 8'd12}, // R12 sharers exactly {2,3}
        '{1'b1, 2'd0, 3'd1, 2'd3, 8'hC3, 4'h0, 2'd2, 2'd2, 8'hC3, 8'd7},  // R7
        '{1'b0, 2'd0, 3'd1, 2'd0, 8'hC3, 4'h0, 2'd0, 2'd0, 8'h00, 8'd8},  // R8
        '{1'b0, 2'd1, 3'd2, 2'd0, 8'h02, 4'h0, 2'd0, 2'd0, 8'h00, 8'd2},
        '{1'b1, 2'd1, 3'd2, 2'd3, 8'h02, 4'h0, 2'd0, 2'd0, 8'h00, 8'd5},  // R5 sole sharer upgrade
        '{1'b1, 2'd1, 3'd2, 2'd3, 8'h02, 4'h0, 2'd0, 2'd0, 8'h00, 8'd5},  // R5 owner rewrite
        '{1'b0, 2'd0, 3'd3, 2'd0, 8'h03, 4'h0, 2'd0, 2'd0, 8'h00, 8'd2},
        '{1'b0, 2'd2, 3'd3, 2'd0, 8'h03, 4'h0, 2'd0, 2'd0, 8'h00, 8'd2},
        '{1'b0, 2'd3, 3'd3, 2'd0, 8'h03, 4'h0, 2'd0, 2'd0, 8'h00, 8'd2},
        '{1'b1, 2'd1, 3'd3, 2'd3, 8'h03, 4'hD, 2'd0, 2'd0, 8'h00, 8'd3},  // R3 three sharers
        '{1'b1, 2'd2, 3'd4, 2'd3, 8'h04, 4'h0, 2'd0, 2'd0, 8'h00, 8'd5},  // R5 uncached write
        '{1'b0, 2'd3, 3'd4, 2'd0, 8'h77, 4'h0, 2'd1, 2'd2, 8'h77, 8'd6}   // R6
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_req(input logic wr, input logic [1:0] node, input logic [2:0] line);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_node = node; req_line = line;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        bit         done  = 0;
        bit         wbp   = 0;
        bit         wbseen = 0;
        logic [3:0] invm  = '0;
        int         cyc   = 0;
        string      tg;
        tg = $sformatf("R%0d", v.tag);
        send_req(v.wr, v.node, v.line);
        while (!done && cyc < 200) begin
            #1;
            rsp_valid = 1'b0;
            msg_ready = 1'b0;
            if (wbp) begin
                rsp_valid = 1'b1; rsp_type = 1'b1; rsp_node = v.own; rsp_data = v.wbd;
                wbp = 0;
            end
            if (msg_valid) begin
                msg_ready = 1'b1;
                if (msg_type == 2'd1) begin
                    invm[msg_node] = 1'b1;
                    rsp_valid = 1'b1; rsp_type = 1'b0; rsp_node = msg_node;
                end else if (msg_type == 2'd2) begin
                    wbseen = 1;
                    chk(msg_node == v.own, {tg, " WBREQ target"}, msg_node, v.own);
                    chk(msg_data == {7'b0, v.wbk == 2'd2}, {tg, " WBREQ drop flag"},
                        msg_data, v.wbk == 2'd2);
                    wbp = 1;
                end else begin
                    done = 1;
                    chk(msg_type == v.fin, "R11 reply type", msg_type, v.fin);
                    chk(msg_node == v.node, {tg, " reply node"}, msg_node, v.node);
                    chk(msg_line == v.line, {tg, " reply line"}, msg_line, v.line);
                    chk(msg_data == v.fdata, {tg, " reply data"}, msg_data, v.fdata);
                end
            end
            @(negedge clk);
            cyc++;
        end
        #1;
        rsp_valid = 1'b0;
        msg_ready = 1'b0;
        chk(done, {tg, " reply seen"}, done, 1);
        chk(invm == v.invm, {tg, " INV recipients"}, invm, v.invm);
        chk(wbseen == (v.wbk != 2'd0), {tg, " WBREQ presence"}, wbseen, v.wbk != 2'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        vec_t rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        chk(msg_valid == 1'b0, "R1 msg_valid after reset", msg_valid, 0);

        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // R9 R10: line 3 is modified at node 1; node 0 reads it
        send_req(1'b0, 2'd0, 3'd3);
        #1;
        chk(msg_valid && msg_type == 2'd2, "R6 WBREQ offered", msg_type, 2);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(msg_valid && msg_type == 2'd2 && msg_node == 2'd1 && msg_data == 8'h00,
                "R10 held message", {msg_type, msg_node}, 9);
            chk(req_ready == 1'b0, "R9 stall during WBREQ", req_ready, 0);
        end
        msg_ready = 1'b1;
        @(negedge clk);
        #1;
        msg_ready = 1'b0;
        chk(req_ready == 1'b0, "R9 stall awaiting write-back", req_ready, 0);
        rsp_valid = 1'b1; rsp_type = 1'b1; rsp_node = 2'd1; rsp_data = 8'h99;
        @(negedge clk);
        #1;
        rsp_valid = 1'b0;
        chk(msg_valid && msg_type == 2'd0 && msg_node == 2'd0 && msg_data == 8'h99,
            "R6 forwarded data", msg_data, 8'h99);
        msg_ready = 1'b1;
        @(negedge clk);
        #1;
        msg_ready = 1'b0;

        // R4: three sharers of line 5, acknowledgements held back
        for (int n = 0; n < 3; n++) begin
            rv = '{1'b0, 2'(n), 3'd5, 2'd0, 8'h05, 4'h0, 2'd0, 2'd0, 8'h00, 8'd2};
            run_vec(rv);
        end
        send_req(1'b1, 2'd3, 3'd5);
        for (int n = 0; n < 3; n++) begin
            #1;
            msg_ready = 1'b1;
            chk(msg_valid && msg_type == 2'd1 && msg_node == 2'(n),
                "R3 INV order", msg_node, n);
            @(negedge clk);
        end
        #1;
        msg_ready = 1'b0;
        for (int n = 0; n < 2; n++) begin
            rsp_valid = 1'b1; rsp_type = 1'b0; rsp_node = 2'(n);
            @(negedge clk);
            #1;
        end
        rsp_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(msg_valid == 1'b0, "R4 no grant with an ACK missing", msg_valid, 0);
        chk(req_ready == 1'b0, "R9 stall with ACK missing", req_ready, 0);
        rsp_valid = 1'b1; rsp_type = 1'b0; rsp_node = 2'd2;
        @(negedge clk);
        #1;
        rsp_valid = 1'b0;
        for (int k = 0; k < 4 && !msg_valid; k++) begin
            @(negedge clk);
            #1;
        end
        chk(msg_valid && msg_type == 2'd3 && msg_node == 2'd3 && msg_data == 8'h05,
            "R4 grant after last ACK", {msg_type, msg_node}, 15);
        msg_ready = 1'b1;
        @(negedge clk);
        #1;
        msg_ready = 1'b0;

        // R12: after the grant, node 0 reads line 5 and only node 3 is asked to write back
        rv = '{1'b0, 2'd0, 3'd5, 2'd0, 8'h3C, 4'h0, 2'd1, 2'd3, 8'h3C, 8'd12};
        run_vec(rv);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule